// File: doc/BRIEF.md
# Programmable-Length Serial Exchange Controller

This block is a full-duplex serial controller seen by the host as four small registers. The host sets a control word: an enable, a role (clock-driving master or clock-following slave), the clock idle level, the clock phase, an interrupt enable, a transfer length of 1 to 16 clocks and a clock divider. Writing the transmit register then starts one exchange. The selected number of bits is shifted out, most significant first, while the same number of bits is shifted in.

In master mode the block generates the serial clock from the system clock. In slave mode it follows an external clock, which it passes through a synchronizer first. The role bit also decides which data pin is driven and which is read. At the end of an exchange the received word can be read, right-aligned. A sticky completion flag is set, and it raises the interrupt output if the interrupt is enabled. The enable bit frames a whole transaction. While it stays set, the host can issue any number of exchanges back to back, so one peripheral access can run longer than 16 clocks. Clearing the enable stops any exchange in progress.

Top module: `spi_xfer_ctrl`

## Requirements
- R1: After reset every register reads 0, `irq` is 0, `sclk_o` is 0 and all three output enables are 0.
- R2: The control register (address 0) reads back the value last written. Its fields are: bit 0 enable, bit 1 master, bit 2 clock idle level, bit 3 phase, bit 4 interrupt enable, bits 11:8 length minus 1, bits 15:12 divider.
- R3: A write to the transmit register (address 1) starts an exchange only when enable is 1 and the block is not busy. Status bit 0 (busy, status at address 3) is then 1 on the following cycle. With enable 0 the write is ignored: busy stays 0, the clock does not toggle and address 1 still reads its old value.
- R4: In master mode `sclk_o` rests at the idle-level bit. Each exchange of N clocks makes exactly 2N clock transitions, spaced divider+1 system cycles apart.
- R5: With phase 0, input data is sampled on the leading clock edge and output data changes on the trailing edge.
- R6: With phase 1, output data changes on the leading edge after the first one, and input data is sampled on the trailing edge. The first output bit is already on the pin before the first leading edge.
- R7: The first bit shifted out is bit N-1 of the transmit register. The received word (address 2) holds the N received bits right-aligned, with bits above N-1 at 0.
- R8: A master drives `mosi_o` and `sclk_o` and reads `miso_i`. A slave drives `miso_o`, reads `mosi_i` and takes its clock from `sclk_i`. Each output enable is 1 only for the pin its role drives, and only while enable is 1.
- R9: When an exchange completes, status bit 1 (done) is set. Writing 1 to that bit clears it. `irq` equals done AND the interrupt enable.
- R10: A new exchange can be started by writing the transmit register again while enable stays 1. Clearing enable in the middle of an exchange drops busy, returns the clock to its idle level and does not set done.
- R11: A write to the transmit register while busy is ignored: the register keeps its value and the exchange in progress sends the original word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0 control, 1 transmit, 2 receive, 3 status) |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for `reg_addr` (combinational) |
| irq | output | 1 | Completion interrupt |
| sclk_o | output | 1 | Serial clock driven in master mode |
| sclk_oe | output | 1 | Serial clock output enable |
| sclk_i | input | 1 | Serial clock received in slave mode |
| mosi_o | output | 1 | Master-out data pin, driven in master mode |
| mosi_oe | output | 1 | Master-out pin enable |
| mosi_i | input | 1 | Master-out data pin, read in slave mode |
| miso_o | output | 1 | Master-in data pin, driven in slave mode |
| miso_oe | output | 1 | Master-in pin enable |
| miso_i | input | 1 | Master-in data pin, read in master mode |

## Verification
The bench builds the block with its defaults: 16-bit words, a 4-bit divider field and a two-stage synchronizer. These values make the longest 16-clock exchange reachable, together with the one-clock minimum. They also cover every divider from a one-cycle half period up to sixteen cycles. In slave mode the bench drives its own clock with a ten-cycle half period. This spacing leaves room for the three-cycle synchronizer latency between an external edge and the block's reaction to it.

// File: rtl/spi_xfer_pkg.sv
package spi_xfer_pkg;

    localparam int REG_AW = 2;

    localparam logic [REG_AW-1:0] ADDR_CTRL = 2'd0;
    localparam logic [REG_AW-1:0] ADDR_TX   = 2'd1;
    localparam logic [REG_AW-1:0] ADDR_RX   = 2'd2;
    localparam logic [REG_AW-1:0] ADDR_STAT = 2'd3;

    localparam int CTRL_EN      = 0;
    localparam int CTRL_MASTER  = 1;
    localparam int CTRL_POL     = 2;
    localparam int CTRL_PHA     = 3;
    localparam int CTRL_IRQEN   = 4;
    localparam int CTRL_LEN_LSB = 8;
    localparam int CTRL_DIV_LSB = 12;

    localparam int STAT_BUSY = 0;
    localparam int STAT_DONE = 1;

endpackage

// File: rtl/spi_clk_gen.sv
module spi_clk_gen #(
    parameter int DIV_W = 4,
    parameter int LEN_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             abort,
    input  logic             pol_i,
    input  logic [DIV_W-1:0] div_i,
    input  logic [LEN_W-1:0] len_i,
    output logic             sclk_o,
    output logic             lead_o,
    output logic             trail_o,
    output logic             active_o
);
    localparam int EDGE_W = LEN_W + 1;

    typedef struct packed {
        logic              active;
        logic              sclk;
        logic              pol;
        logic [DIV_W-1:0]  div;
        logic [DIV_W-1:0]  cnt;
        logic [EDGE_W-1:0] left;
    } gen_t;

    gen_t q, d;
    logic tick;

    always_comb begin
        tick    = q.active && (q.cnt == q.div);
        lead_o  = tick && (q.sclk == q.pol);
        trail_o = tick && (q.sclk != q.pol);
        d = q;
        if (abort) begin
            d.active = 1'b0;
            d.sclk   = pol_i;
            d.cnt    = '0;
        end else if (start) begin
            d.active = 1'b1;
            d.sclk   = pol_i;
            d.pol    = pol_i;
            d.div    = div_i;
            d.cnt    = '0;
            d.left   = {len_i, 1'b1};
        end else if (q.active) begin
            if (tick) begin
                d.cnt  = '0;
                d.sclk = ~q.sclk;
                if (q.left == '0) begin
                    d.active = 1'b0;
                end else begin
                    d.left = q.left - 1'b1;
                end
            end else begin
                d.cnt = q.cnt + 1'b1;
            end
        end else begin
            d.sclk = pol_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign sclk_o   = q.sclk;
    assign active_o = q.active;

endmodule

// File: rtl/spi_sclk_sync.sv
module spi_sclk_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_i,
    input  logic din_i,
    input  logic pol_i,
    output logic lead_o,
    output logic trail_o,
    output logic din_o
);
    typedef struct packed {
        logic [STAGES:0]   ck;
        logic [STAGES-1:0] dt;
    } sync_t;

    sync_t q, d;
    logic  moved;

    always_comb begin
        d       = q;
        d.ck    = q.ck << 1;
        d.ck[0] = sclk_i;
        d.dt    = q.dt << 1;
        d.dt[0] = din_i;
        moved   = q.ck[STAGES] != q.ck[STAGES-1];
        lead_o  = moved && (q.ck[STAGES-1] != pol_i);
        trail_o = moved && (q.ck[STAGES-1] == pol_i);
        din_o   = q.dt[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

endmodule

// File: rtl/spi_shift_core.sv
module spi_shift_core #(
    parameter int DATA_W = 16,
    parameter int LEN_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              abort,
    input  logic [DATA_W-1:0] tx_i,
    input  logic [LEN_W-1:0]  len_i,
    input  logic              pha_i,
    input  logic              lead_i,
    input  logic              trail_i,
    input  logic              sin_i,
    output logic              sout_o,
    output logic              busy_o,
    output logic              done_o,
    output logic [DATA_W-1:0] rx_o
);
    typedef struct packed {
        logic              busy;
        logic              pha;
        logic              skip;
        logic              done;
        logic [LEN_W-1:0]  len;
        logic [LEN_W-1:0]  cnt;
        logic [DATA_W-1:0] tx_sh;
        logic [DATA_W-1:0] rx_sh;
        logic [DATA_W-1:0] rx;
    } core_t;

    core_t q, d;
    logic  sample_evt;
    logic  shift_evt;
    logic [DATA_W-1:0] rx_next;

    always_comb begin
        sample_evt = q.pha ? trail_i : lead_i;
        shift_evt  = q.pha ? lead_i  : trail_i;
        rx_next    = {q.rx_sh[DATA_W-2:0], sin_i};
        d          = q;
        d.done     = 1'b0;
        if (abort) begin
            d.busy = 1'b0;
            d.skip = 1'b0;
        end else if (start) begin
            d.busy  = 1'b1;
            d.pha   = pha_i;
            d.skip  = pha_i;
            d.len   = len_i;
            d.cnt   = '0;
            d.tx_sh = tx_i;
            d.rx_sh = '0;
        end else if (q.busy) begin
            if (shift_evt) begin
                if (q.skip) d.skip  = 1'b0;
                else        d.tx_sh = q.tx_sh << 1;
            end
            if (sample_evt) begin
                d.rx_sh = rx_next;
                if (q.cnt == q.len) begin
                    d.busy = 1'b0;
                    d.done = 1'b1;
                    d.rx   = rx_next;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign sout_o = q.tx_sh[q.len];
    assign busy_o = q.busy;
    assign done_o = q.done;
    assign rx_o   = q.rx;

endmodule

// File: rtl/spi_xfer_ctrl.sv
module spi_xfer_ctrl
    import spi_xfer_pkg::*;
#(
    parameter int DATA_W      = 16,
    parameter int DIV_W       = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq,
    output logic              sclk_o,
    output logic              sclk_oe,
    input  logic              sclk_i,
    output logic              mosi_o,
    output logic              mosi_oe,
    input  logic              mosi_i,
    output logic              miso_o,
    output logic              miso_oe,
    input  logic              miso_i
);
    localparam int LEN_W = $clog2(DATA_W);

    typedef struct packed {
        logic [DATA_W-1:0] ctrl;
        logic [DATA_W-1:0] tx;
        logic              done;
    } regs_t;

    regs_t q, d;

    logic              ctrl_en, ctrl_master, ctrl_pol, ctrl_pha, ctrl_irqen;
    logic [LEN_W-1:0]  ctrl_len;
    logic [DIV_W-1:0]  ctrl_div;
    logic              core_busy, core_done, core_sout;
    logic [DATA_W-1:0] core_rx;
    logic              gen_active, gen_lead, gen_trail, gen_sclk;
    logic              sync_lead, sync_trail, sync_din;
    logic              busy_any, xfer_start;
    logic              lead_sel, trail_sel, sin_sel;

    assign ctrl_en     = q.ctrl[CTRL_EN];
    assign ctrl_master = q.ctrl[CTRL_MASTER];
    assign ctrl_pol    = q.ctrl[CTRL_POL];
    assign ctrl_pha    = q.ctrl[CTRL_PHA];
    assign ctrl_irqen  = q.ctrl[CTRL_IRQEN];
    assign ctrl_len    = q.ctrl[CTRL_LEN_LSB +: LEN_W];
    assign ctrl_div    = q.ctrl[CTRL_DIV_LSB +: DIV_W];
    assign done_flag   = q.done;

    logic done_flag;

    always_comb begin
        busy_any   = core_busy | gen_active;
        xfer_start = reg_wr && (reg_addr == ADDR_TX) && ctrl_en && !busy_any;
        lead_sel   = ctrl_master ? gen_lead  : sync_lead;
        trail_sel  = ctrl_master ? gen_trail : sync_trail;
        sin_sel    = ctrl_master ? miso_i    : sync_din;

        d = q;
        if (reg_wr && (reg_addr == ADDR_CTRL)) d.ctrl = reg_wdata;
        if (xfer_start)                        d.tx   = reg_wdata;
        if (reg_wr && (reg_addr == ADDR_STAT) && reg_wdata[STAT_DONE]) d.done = 1'b0;
        if (core_done)                         d.done = 1'b1;

        reg_rdata = '0;
        case (reg_addr)
            ADDR_CTRL: reg_rdata = q.ctrl;
            ADDR_TX:   reg_rdata = q.tx;
            ADDR_RX:   reg_rdata = core_rx;
            default: begin
                reg_rdata[STAT_BUSY] = busy_any;
                reg_rdata[STAT_DONE] = q.done;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    spi_clk_gen #(.DIV_W(DIV_W), .LEN_W(LEN_W)) u_gen (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (xfer_start && ctrl_master),
        .abort    (!ctrl_en),
        .pol_i    (ctrl_pol),
        .div_i    (ctrl_div),
        .len_i    (ctrl_len),
        .sclk_o   (gen_sclk),
        .lead_o   (gen_lead),
        .trail_o  (gen_trail),
        .active_o (gen_active)
    );

    spi_sclk_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .sclk_i  (sclk_i),
        .din_i   (mosi_i),
        .pol_i   (ctrl_pol),
        .lead_o  (sync_lead),
        .trail_o (sync_trail),
        .din_o   (sync_din)
    );

    spi_shift_core #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (xfer_start),
        .abort   (!ctrl_en),
        .tx_i    (reg_wdata),
        .len_i   (ctrl_len),
        .pha_i   (ctrl_pha),
        .lead_i  (lead_sel),
        .trail_i (trail_sel),
        .sin_i   (sin_sel),
        .sout_o  (core_sout),
        .busy_o  (core_busy),
        .done_o  (core_done),
        .rx_o    (core_rx)
    );

    assign irq     = q.done & ctrl_irqen;
    assign sclk_o  = gen_sclk;
    assign sclk_oe = ctrl_en & ctrl_master;
    assign mosi_o  = ctrl_master & core_sout;
    assign mosi_oe = ctrl_en & ctrl_master;
    assign miso_o  = ~ctrl_master & core_sout;
    assign miso_oe = ctrl_en & ~ctrl_master;

endmodule

// File: rtl/spi_xfer_checker.sv
module spi_xfer_checker (
    input logic clk,
    input logic rst_n,
    input logic ctrl_en,
    input logic ctrl_master,
    input logic ctrl_pol,
    input logic core_busy,
    input logic gen_active,
    input logic done_flag,
    input logic sclk_o,
    input logic mosi_oe,
    input logic miso_oe
);
    // R3: an exchange only begins while the enable bit is set
    assert_start_gated_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(core_busy) |-> $past(ctrl_en));

    // R10: clearing enable stops both shifter and clock generator
    assert_abort_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_en |=> (!core_busy && !gen_active));

    // R4: an idle master clock rests at the programmed idle level
    assert_idle_level_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_master && !gen_active && !$past(gen_active) && $stable(ctrl_pol))
        |-> (sclk_o == ctrl_pol));

    // R8: never drive both data pins
    assert_oe_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(mosi_oe && miso_oe));

    // R9: done only rises as the result of a finished exchange
    assert_done_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_flag) |-> $past(core_busy, 2));

endmodule

bind spi_xfer_ctrl spi_xfer_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ctrl_en     (ctrl_en),
    .ctrl_master (ctrl_master),
    .ctrl_pol    (ctrl_pol),
    .core_busy   (core_busy),
    .gen_active  (gen_active),
    .done_flag   (done_flag),
    .sclk_o      (sclk_o),
    .mosi_oe     (mosi_oe),
    .miso_oe     (miso_oe)
);

// File: tb/spi_xfer_ctrl_tb.sv
module spi_xfer_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [15:0] reg_wdata = 16'd0;
    logic [15:0] reg_rdata;
    logic        irq, sclk_o, sclk_oe, mosi_o, mosi_oe, miso_o, miso_oe;
    logic        sclk_i = 1'b0;
    logic        mosi_i = 1'b0;
    logic        miso_i = 1'b0;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    // bench-side slave model state (master-mode tests)
    bit          m_on = 0;
    bit          m_pol, m_pha;
    logic [15:0] s_tx, s_rx;
    int          s_idx;
    logic        prev_sclk = 1'b0;
    int          edges;
    int          last_edge;
    int          exp_half;
    bit          first_edge;
    bit          gap_bad;

    spi_xfer_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
        .sclk_o(sclk_o), .sclk_oe(sclk_oe), .sclk_i(sclk_i),
        .mosi_o(mosi_o), .mosi_oe(mosi_oe), .mosi_i(mosi_i),
        .miso_o(miso_o), .miso_oe(miso_oe), .miso_i(miso_i)
    );

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (m_on && (sclk_o !== prev_sclk)) begin
            if (!first_edge && ((cyc - last_edge) != exp_half)) gap_bad = 1;
            first_edge = 0;
            last_edge  = cyc;
            edges++;
            if (prev_sclk == m_pol) begin
                if (!m_pha) s_rx = {s_rx[14:0], mosi_o};
                else begin
                    if (s_idx >= 0) miso_i = s_tx[s_idx];
                    s_idx--;
                end
            end else begin
                if (!m_pha) begin
                    s_idx--;
                    if (s_idx >= 0) miso_i = s_tx[s_idx];
                end else s_rx = {s_rx[14:0], mosi_o};
            end
        end
        prev_sclk = sclk_o;
    end

    function automatic logic [15:0] nmask(int n);
        return (n >= 16) ? 16'hFFFF : ((16'h1 << n) - 16'h1);
    endfunction

    function automatic logic [15:0] ctrl_word(bit en, bit mst, bit pol, bit pha,
                                              bit ie, int n, int dv);
        logic [15:0] w;
        w = '0;
        w[0] = en; w[1] = mst; w[2] = pol; w[3] = pha; w[4] = ie;
        w[11:8]  = 4'(n - 1);
        w[15:12] = 4'(dv);
        return w;
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [1:0] a, logic [15:0] v);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(logic [1:0] a, output logic [15:0] v);
        @(negedge clk);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic wait_idle();
        logic [15:0] v;
        for (int i = 0; i < 4000; i++) begin
            rd(2'd3, v);
            if (!v[0]) break;
        end
        repeat (3) @(negedge clk);
    endtask

    task automatic arm_model(bit pol, bit pha, int n, int dv, logic [15:0] sw);
        m_pol = pol; m_pha = pha; s_tx = sw; s_rx = '0; s_idx = n - 1;
        edges = 0; exp_half = dv + 1; first_edge = 1; gap_bad = 0;
        if (!pha) miso_i = sw[n-1];
        prev_sclk = sclk_o;
        m_on = 1;
    endtask

    task automatic run_master(bit pol, bit pha, int n, int dv, bit ie,
                              logic [15:0] txw, logic [15:0] sw, bit rewrite);
        logic [15:0] v;
        string dtag;
        dtag = pha ? "R6" : "R5";
        if (rewrite) wr(2'd0, ctrl_word(1, 1, pol, pha, ie, n, dv));
        repeat (2) @(negedge clk);
        arm_model(pol, pha, n, dv, sw);
        wr(2'd1, txw);
        if (n >= 2) begin
            rd(2'd3, v);
            chk("R3 busy after TX write", {31'd0, v[0]}, 32'd1);
        end
        chk("R8 master pin enables", {29'd0, sclk_oe, mosi_oe, miso_oe}, 32'b110);
        wait_idle();
        m_on = 0;
        chk("R4 clock transitions", edges, 2 * n);
        chk("R4 half period", {31'd0, gap_bad}, 32'd0);
        chk("R4 idle level", {31'd0, sclk_o}, {31'd0, pol});
        rd(2'd2, v);
        chk({dtag, " R7 master received word"}, {16'd0, v}, {16'd0, sw & nmask(n)});
        chk({dtag, " R7 peripheral received word"}, {16'd0, s_rx & nmask(n)}, {16'd0, txw & nmask(n)});
        rd(2'd3, v);
        chk("R9 done set", {31'd0, v[1]}, 32'd1);
        chk("R9 irq gated", {31'd0, irq}, {31'd0, ie});
        wr(2'd3, 16'h0002);
        rd(2'd3, v);
        chk("R9 done cleared", {30'd0, v[1], irq}, 32'd0);
    endtask

    task automatic run_slave(bit pol, bit pha, int n, logic [15:0] txw, logic [15:0] mw);
        logic [15:0] v;
        logic [15:0] cap;
        string dtag;
        dtag = pha ? "R6" : "R5";
        cap = '0;
        sclk_i = pol;
        wr(2'd0, ctrl_word(1, 0, pol, pha, 0, n, 0));
        repeat (6) @(negedge clk);
        wr(2'd1, txw);
        chk("R8 slave pin enables", {29'd0, sclk_oe, mosi_oe, miso_oe}, 32'b001);
        if (!pha) mosi_i = mw[n-1];
        for (int i = n - 1; i >= 0; i--) begin
            repeat (10) @(negedge clk);
            if (!pha) cap = {cap[14:0], miso_o};
            sclk_i = ~pol;
            if (pha) mosi_i = mw[i];
            repeat (10) @(negedge clk);
            if (pha) cap = {cap[14:0], miso_o};
            sclk_i = pol;
            if (!pha && i > 0) mosi_i = mw[i-1];
        end
        repeat (10) @(negedge clk);
        rd(2'd3, v);
        chk("R8 slave done, not busy", {30'd0, v[1:0]}, 32'b10);
        rd(2'd2, v);
        chk({dtag, " R8 slave received word"}, {16'd0, v}, {16'd0, mw & nmask(n)});
        chk({dtag, " R7 slave sent word"}, {16'd0, cap & nmask(n)}, {16'd0, txw & nmask(n)});
        wr(2'd3, 16'h0002);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [15:0] v;
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1: reset state
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), v);
            chk("R1 register reset value", {16'd0, v}, 32'd0);
        end
        chk("R1 pins at reset", {28'd0, irq, sclk_o, sclk_oe, mosi_oe | miso_oe}, 32'd0);

        // R2: control readback
        wr(2'd0, 16'h5A16);
        rd(2'd0, v);
        chk("R2 control readback", {16'd0, v}, 32'h5A16);
        wr(2'd0, 16'h0000);

        // R3: TX write with enable clear is ignored
        wr(2'd0, ctrl_word(0, 1, 0, 0, 0, 8, 1));
        arm_model(0, 0, 8, 1, 16'h0);
        wr(2'd1, 16'h1234);
        repeat (30) @(negedge clk);
        m_on = 0;
        rd(2'd3, v);
        chk("R3 no busy when disabled", {31'd0, v[0]}, 32'd0);
        chk("R3 no clock when disabled", edges, 0);
        rd(2'd1, v);
        chk("R3 TX unchanged when disabled", {16'd0, v}, 32'd0);

        // directed master corners
        run_master(0, 0, 8, 1, 1, 16'h00A5, 16'h003C, 1);
        run_master(1, 1, 16, 0, 0, 16'hC3A1, 16'h7E19, 1);
        run_master(0, 1, 1, 2, 1, 16'h0001, 16'h0001, 1);
        run_master(1, 0, 5, 15, 0, 16'hFFF3, 16'hFFEA, 1);
        run_master(0, 0, 16, 0, 1, 16'h8001, 16'h4002, 1);

        // R10: chained exchanges under one enable
        run_master(1, 0, 12, 1, 1, 16'h0ABC, 16'h0DEF, 1);
        run_master(1, 0, 12, 1, 1, 16'h0F0F, 16'h0123, 0);

        // random master exchanges
        for (int k = 0; k < 12; k++) begin
            run_master(1'($urandom), 1'($urandom), 1 + int'($urandom % 16),
                       int'($urandom % 4), 1'($urandom),
                       16'($urandom), 16'($urandom), 1);
        end

        // R11: TX write while busy is ignored
        wr(2'd0, ctrl_word(1, 1, 0, 0, 0, 8, 3));
        repeat (2) @(negedge clk);
        arm_model(0, 0, 8, 3, 16'h0055);
        wr(2'd1, 16'h00C6);
        wr(2'd1, 16'h0039);
        rd(2'd1, v);
        chk("R11 TX kept while busy", {16'd0, v}, 32'h00C6);
        wait_idle();
        m_on = 0;
        chk("R11 original word sent", {16'd0, s_rx & 16'h00FF}, 32'h00C6);
        wr(2'd3, 16'h0002);

        // R10: abort by clearing enable
        wr(2'd0, ctrl_word(1, 1, 1, 0, 1, 16, 7));
        repeat (2) @(negedge clk);
        wr(2'd1, 16'hBEEF);
        repeat (40) @(negedge clk);
        wr(2'd0, ctrl_word(0, 1, 1, 0, 1, 16, 7));
        repeat (2) @(negedge clk);
        rd(2'd3, v);
        chk("R10 abort clears busy, no done", {30'd0, v[1:0]}, 32'd0);
        chk("R10 clock back to idle", {31'd0, sclk_o}, 32'd1);
        chk("R8 enables off when disabled", {29'd0, sclk_oe, mosi_oe, miso_oe}, 32'd0);

        // slave exchanges
        run_slave(0, 0, 8, 16'h00B4, 16'h0069);
        run_slave(1, 1, 16, 16'hA55A, 16'h3CC3);
        run_slave(0, 1, 3, 16'h0005, 16'h0002);
        run_slave(1, 0, 1, 16'h0001, 16'h0001);
        for (int k = 0; k < 4; k++) begin
            run_slave(1'($urandom), 1'($urandom), 1 + int'($urandom % 16),
                      16'($urandom), 16'($urandom));
        end

        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule